// File: doc/BRIEF.md
# Pipelined tag compare RAM

A single-port synchronous tag memory of 18-bit words, each split into a lower and an upper 9-bit byte lane, with a parameterised depth (64 words by default). Every input is captured on the rising clock edge: the word address, the data bus, three chip enables (two active low, one active high), a byte-write gate with two lane strobes, a global write strobe and a data-capture enable. Each captured cycle is decoded into one of five operation states, and the operation is carried out at the following edge.

Besides reading and writing, the block holds a separate capture register for input data. That register is the operand for compare cycles, which check it against the addressed word and publish an equality flag one edge later. It is also the source for fill writes, which store the held value without sampling the bus. Three-state pads are modelled as a value output plus a drive-enable output; the two output enables act combinationally.

Operation states (the decoded cycle register): ST_DESEL, ST_READ, ST_WRITE, ST_FILL and ST_CMP. Transitions: at every edge the state register takes the operation decoded from that edge's inputs. Any enable off goes to ST_DESEL. Selected with the write strobe active goes to ST_WRITE when capture is enabled and to ST_FILL when it is not. Selected with the write strobe idle goes to ST_CMP when capture is enabled and to ST_READ when it is not. Reset forces ST_DESEL.

Top module: `tag_cmp_ram`

## Requirements
- R1: The block is selected only when en_a_n = 0, en_b_n = 0 and en_c = 1; any other combination is a deselect cycle that changes no stored word and no capture register.
- R2: The capture register loads data_in at an edge only when the block is selected and din_en_n = 0; otherwise it keeps its value.
- R3: The effective write strobe is active when gw_n = 0, or when bw_n = 0 together with wr_lo_n = 0 or wr_hi_n = 0; gw_n = 0 writes all 18 bits whatever the other write inputs are.
- R4: wr_lo_n gates bits [8:0] and wr_hi_n gates bits [17:9], and only while bw_n = 0; with bw_n = 1 and gw_n = 1 the cycle is not a write and memory is unchanged.
- R5: A selected cycle with the write strobe idle and din_en_n = 0 is a compare: the capture register loads at that edge and is compared with the addressed word, and match_out shows the result only after the next edge.
- R6: match_out is 1 on equality and 0 on mismatch. A deselect cycle sets match_out to 1 one edge after it is captured. Read and write cycles leave match_out unchanged. match_oe = 1 requires moe_n = 0.
- R7: A fill write (selected, write strobe active, din_en_n = 1) stores the held capture register through the enabled lanes, ignores data_in, and leaves data_oe = 0.
- R8: A normal write (selected, write strobe active, din_en_n = 0) stores data_in through the enabled lanes and leaves data_oe = 0.
- R9: A read (selected, write strobe idle, din_en_n = 1) captured at edge N presents the word on data_out after edge N+1. data_oe = 1 requires oe_n = 0 and a read as the most recently completed operation. oe_n and moe_n act without a clock.
- R10: While the synchronous reset rst is high, data_out, match_out, data_oe and match_oe are 0 at every edge, whatever oe_n and moe_n are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| data_in | input | 2*BYTE_W | Data bus, input side |
| en_a_n | input | 1 | Chip enable, active low |
| en_b_n | input | 1 | Chip enable, active low |
| en_c | input | 1 | Chip enable, active high |
| gw_n | input | 1 | Global write, all lanes, active low |
| bw_n | input | 1 | Byte-write gate, active low |
| wr_lo_n | input | 1 | Lower lane write strobe, active low |
| wr_hi_n | input | 1 | Upper lane write strobe, active low |
| din_en_n | input | 1 | Capture-register load enable, active low |
| oe_n | input | 1 | Data output enable, active low, combinational |
| moe_n | input | 1 | Match output enable, active low, combinational |
| data_out | output | 2*BYTE_W | Data bus, output value |
| data_oe | output | 1 | Data bus drive-enable |
| match_out | output | 1 | Registered compare flag |
| match_oe | output | 1 | Match drive-enable |

## Verification
The bench samples match_out after the edge that captures a compare and again one edge later. A design that publishes the flag a cycle early fails the first sample, and one that leaves it sticky fails the mismatch case. Fill writes are checked after the capture register has first been loaded, then held through a read and through a deselect cycle that carries din_en_n = 0, each on a different bus value. Storing bus data, or loading the capture register while deselected, therefore shows up as a wrong word. Each of the three enables is flipped alone during a global write to expose a partial select decode. Lane writes are checked with bw_n both low and high to catch strobes that ignore the gate. A read followed at once by a write or a fill shows whether the write clears the data drive-enable.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    localparam int LANES = 2;

    typedef enum logic [2:0] {
        ST_DESEL = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_FILL  = 3'd3,
        ST_CMP   = 3'd4
    } op_t;
endpackage

// File: rtl/tcr_decode.sv
module tcr_decode
    import tcr_pkg::*;
(
    input  logic             en_a_n,
    input  logic             en_b_n,
    input  logic             en_c,
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic             wr_lo_n,
    input  logic             wr_hi_n,
    input  logic             din_en_n,
    output op_t              op,
    output logic             sel,
    output logic [LANES-1:0] lanes
);
    logic we_n;

    always_comb begin
        sel      = !en_a_n && !en_b_n && en_c;
        we_n     = (bw_n | (wr_lo_n & wr_hi_n)) & gw_n;
        lanes[0] = !gw_n | (!bw_n & !wr_lo_n);
        lanes[1] = !gw_n | (!bw_n & !wr_hi_n);
        if (!sel)
            op = ST_DESEL;
        else if (!we_n)
            op = din_en_n ? ST_FILL : ST_WRITE;
        else
            op = din_en_n ? ST_READ : ST_CMP;
    end

    // R3/R4: an active write strobe always enables at least one lane
    always_comb begin
        if (sel && !we_n)
            a_r4_write_has_lane: assert (lanes != '0);
    end
endmodule

// File: rtl/tcr_array.sv
module tcr_array
    import tcr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*BYTE_W-1:0] wdata,
    output logic [LANES*BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[i])
                mem[addr] <= wdata[i*BYTE_W +: BYTE_W];
        end

        assign rdata[i*BYTE_W +: BYTE_W] = mem[addr];
    end
endmodule

// File: rtl/tag_cmp_ram.sv
module tag_cmp_ram
    import tcr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [2*BYTE_W-1:0]     data_in,
    input  logic                    en_a_n,
    input  logic                    en_b_n,
    input  logic                    en_c,
    input  logic                    gw_n,
    input  logic                    bw_n,
    input  logic                    wr_lo_n,
    input  logic                    wr_hi_n,
    input  logic                    din_en_n,
    input  logic                    oe_n,
    input  logic                    moe_n,
    output logic [2*BYTE_W-1:0]     data_out,
    output logic                    data_oe,
    output logic                    match_out,
    output logic                    match_oe
);
    localparam int WORD_W = LANES * BYTE_W;

    op_t               op_d, op_q;
    logic              sel_d;
    logic [LANES-1:0]  lanes_d, lane_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] din_q, q_r, rd_word;
    logic [LANES-1:0]  arr_we;
    logic              rd_vld, match_r, m_vld;

    tcr_decode u_dec (
        .en_a_n   (en_a_n),
        .en_b_n   (en_b_n),
        .en_c     (en_c),
        .gw_n     (gw_n),
        .bw_n     (bw_n),
        .wr_lo_n  (wr_lo_n),
        .wr_hi_n  (wr_hi_n),
        .din_en_n (din_en_n),
        .op       (op_d),
        .sel      (sel_d),
        .lanes    (lanes_d)
    );

    // state register: the decoded operation of the captured cycle
    always_ff @(posedge clk) begin
        if (rst)
            op_q <= ST_DESEL;
        else
            op_q <= op_d;
    end

    // input capture stage
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            lane_q <= '0;
            din_q  <= '0;
        end else begin
            addr_q <= addr;
            lane_q <= lanes_d;
            if (sel_d && !din_en_n)
                din_q <= data_in;
        end
    end

    always_comb begin
        arr_we = (op_q == ST_WRITE || op_q == ST_FILL) ? lane_q : '0;
    end

    tcr_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .addr  (addr_q),
        .wdata (din_q),
        .rdata (rd_word)
    );

    // output process: acts on the state captured one edge earlier
    always_ff @(posedge clk) begin
        if (rst) begin
            q_r     <= '0;
            rd_vld  <= 1'b0;
            match_r <= 1'b0;
            m_vld   <= 1'b0;
        end else begin
            unique case (op_q)
                ST_DESEL: begin
                    match_r <= 1'b1;
                    m_vld   <= 1'b1;
                    rd_vld  <= 1'b0;
                end
                ST_READ: begin
                    q_r    <= rd_word;
                    rd_vld <= 1'b1;
                end
                ST_WRITE, ST_FILL: begin
                    rd_vld <= 1'b0;
                end
                ST_CMP: begin
                    match_r <= (rd_word == din_q);
                    m_vld   <= 1'b1;
                    rd_vld  <= 1'b0;
                end
                default: rd_vld <= 1'b0;
            endcase
        end
    end

    assign data_out  = q_r;
    assign data_oe   = !oe_n && rd_vld;
    assign match_out = match_r;
    assign match_oe  = !moe_n && m_vld;

    // R2: capture register holds unless a selected cycle enables loading
    a_r2_din_hold: assert property (@(posedge clk) disable iff (rst)
        (!sel_d || din_en_n) |=> $stable(din_q));

    // R3: global write enables both lanes regardless of other strobes
    a_r3_global_all_lanes: assert property (@(posedge clk) disable iff (rst)
        (sel_d && !gw_n) |=> (lane_q == '1));

    // R6: a completed deselect leaves the flag high
    a_r6_desel_match_high: assert property (@(posedge clk) disable iff (rst)
        (op_q == ST_DESEL) |=> match_r);

    // R7/R8: a completed write or fill never drives the data bus
    a_r7_write_no_drive: assert property (@(posedge clk) disable iff (rst)
        (op_q == ST_WRITE || op_q == ST_FILL) |=> !data_oe);

    // R10: reset clears outputs and drive-enables
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (!data_oe && !match_oe && !match_out && data_out == '0));
endmodule

// File: tb/tag_cmp_ram_tb.sv
module tag_cmp_ram_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  addr;
    logic [17:0] data_in;
    logic        en_a_n, en_b_n, en_c, gw_n, bw_n, wr_lo_n, wr_hi_n, din_en_n;
    logic        oe_n, moe_n;
    logic [17:0] data_out;
    logic        data_oe, match_out, match_oe;

    int checks = 0;
    int fails  = 0;

    localparam logic [2:0] SEL = 3'b001; // {en_a_n, en_b_n, en_c}
    localparam logic [2:0] NOP = 3'b101;

    always #10 clk = ~clk;

    tag_cmp_ram u_dut (
        .clk(clk), .rst(rst), .addr(addr), .data_in(data_in),
        .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
        .gw_n(gw_n), .bw_n(bw_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
        .din_en_n(din_en_n), .oe_n(oe_n), .moe_n(moe_n),
        .data_out(data_out), .data_oe(data_oe),
        .match_out(match_out), .match_oe(match_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_in(input logic [2:0] en, input logic g, input logic b,
                          input logic lo, input logic hi, input logic dn,
                          input logic [5:0] a, input logic [17:0] v);
        {en_a_n, en_b_n, en_c} = en;
        gw_n = g; bw_n = b; wr_lo_n = lo; wr_hi_n = hi; din_en_n = dn;
        addr = a; data_in = v;
    endtask

    task automatic set_nop();
        set_in(NOP, 1, 1, 1, 1, 1, 6'd0, 18'd0);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [17:0] v);
        tick(); set_in(SEL, 0, 1, 1, 1, 0, a, v);
        tick(); set_nop();
    endtask

    task automatic read_chk(input string tag, input logic [5:0] a, input logic [17:0] exp);
        tick(); set_in(SEL, 1, 1, 1, 1, 1, a, 18'h3FFFF);
        tick(); set_nop();
        tick();
        chk(tag, 32'(data_out), 32'(exp));
        chk({tag, " oe"}, 32'(data_oe), 32'd1);
    endtask

    task automatic cmp_chk(input string tag, input logic [5:0] a, input logic [17:0] v,
                           input logic exp);
        tick(); set_in(SEL, 1, 1, 1, 1, 0, a, v);
        tick();
        chk({tag, " early"}, 32'(match_out), 32'd1);
        set_nop();
        tick();
        chk(tag, 32'(match_out), 32'(exp));
        chk({tag, " moe"}, 32'(match_oe), 32'd1);
    endtask

    task automatic t_reset();
        rst = 1; oe_n = 0; moe_n = 0; set_nop();
        repeat (3) tick();
        chk("R10 data_oe", 32'(data_oe), 0);
        chk("R10 match_oe", 32'(match_oe), 0);
        chk("R10 match_out", 32'(match_out), 0);
        chk("R10 data_out", 32'(data_out), 0);
        rst = 0;
        tick();
    endtask

    task automatic t_global_write();
        do_write(6'd5, 18'h2A5A5);
        read_chk("R3 global write", 6'd5, 18'h2A5A5);
        oe_n = 1; #1;
        chk("R9 oe_n gates data_oe", 32'(data_oe), 0);
        oe_n = 0; #1;
        chk("R9 oe_n restores", 32'(data_oe), 1);
        // gw_n low overrides bw_n/lane strobes held inactive
        tick(); set_in(SEL, 0, 1, 1, 1, 0, 6'd6, 18'h13579);
        tick(); set_nop();
        read_chk("R3 gw ignores lanes", 6'd6, 18'h13579);
    endtask

    task automatic t_byte_write();
        do_write(6'd7, 18'h0F0F0);
        tick(); set_in(SEL, 1, 0, 0, 1, 0, 6'd7, 18'h3FFFF);
        tick(); set_nop();
        read_chk("R4 lower lane", 6'd7, (18'h0F0F0 & ~18'h001FF) | 18'h001FF);
        tick(); set_in(SEL, 1, 0, 1, 0, 0, 6'd7, 18'h00000);
        tick(); set_nop();
        read_chk("R4 upper lane", 6'd7, 18'h001FF);
        tick(); set_in(SEL, 1, 1, 0, 0, 0, 6'd7, 18'h2AAAA);
        tick(); set_nop();
        read_chk("R4 bw_n high no write", 6'd7, 18'h001FF);
    endtask

    task automatic t_deselect();
        do_write(6'd9, 18'h11111);
        tick(); set_in(3'b101, 0, 1, 1, 1, 0, 6'd9, 18'h0); tick(); set_nop();
        read_chk("R1 en_a_n high", 6'd9, 18'h11111);
        tick(); set_in(3'b011, 0, 1, 1, 1, 0, 6'd9, 18'h0); tick(); set_nop();
        read_chk("R1 en_b_n high", 6'd9, 18'h11111);
        tick(); set_in(3'b000, 0, 1, 1, 1, 0, 6'd9, 18'h0); tick(); set_nop();
        read_chk("R1 en_c low", 6'd9, 18'h11111);
        tick(); tick();
        chk("R6 deselect match high", 32'(match_out), 1);
        moe_n = 1; #1;
        chk("R6 moe_n gates match_oe", 32'(match_oe), 0);
        moe_n = 0;
    endtask

    task automatic t_compare();
        cmp_chk("R5 compare equal", 6'd5, 18'h2A5A5, 1'b1);
        cmp_chk("R6 compare mismatch", 6'd5, 18'h2A5A4, 1'b0);
        // mismatch then read at once: flag must hold through the read
        tick(); set_in(SEL, 1, 1, 1, 1, 0, 6'd6, 18'h0);
        tick(); set_in(SEL, 1, 1, 1, 1, 1, 6'd6, 18'h0);
        tick(); set_nop();
        chk("R6 mismatch result", 32'(match_out), 0);
        tick();
        chk("R6 read holds match", 32'(match_out), 0);
        chk("R9 read data", 32'(data_out), 32'h13579);
    endtask

    task automatic t_fill();
        do_write(6'd10, 18'h11223);
        tick(); set_in(SEL, 1, 1, 1, 1, 0, 6'd10, 18'h2BEEF); // compare loads capture
        tick(); set_in(SEL, 1, 1, 1, 1, 1, 6'd11, 18'h0CAFE); // read, no load
        tick(); set_in(SEL, 0, 1, 1, 1, 1, 6'd12, 18'h3D00D); // fill right after read
        tick(); set_in(NOP, 1, 1, 1, 1, 0, 6'd0, 18'h15555);  // deselect, din_en_n low
        chk("R9 read drives before fill", 32'(data_oe), 1);
        tick(); set_nop();
        chk("R7 fill no drive", 32'(data_oe), 0);
        read_chk("R7 fill stores held capture", 6'd12, 18'h2BEEF);
        tick(); set_in(SEL, 0, 1, 1, 1, 1, 6'd13, 18'h00001);
        tick(); set_nop();
        read_chk("R2 deselect does not load", 6'd13, 18'h2BEEF);
    endtask

    task automatic t_write_no_drive();
        tick(); set_in(SEL, 1, 1, 1, 1, 1, 6'd5, 18'h0);
        tick(); set_in(SEL, 0, 1, 1, 1, 0, 6'd14, 18'h0ABCD);
        tick(); set_nop();
        chk("R9 read drives", 32'(data_oe), 1);
        tick();
        chk("R8 write no drive", 32'(data_oe), 0);
        read_chk("R8 write stored", 6'd14, 18'h0ABCD);
    endtask

    initial begin
        t_reset();
        t_global_write();
        t_byte_write();
        t_deselect();
        t_compare();
        t_fill();
        t_write_no_drive();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule